// File: doc/BRIEF.md
# Memory-card SPI-mode bring-up sequencer

This block takes a memory card from power-on into SPI mode and then through its activation loop. It has no serial shifter of its own: it sits in front of a byte-exchange port. For each transfer it offers one transmit byte and takes back the byte the card returned. It drives the card's chip select directly. A host starts it with a one-cycle pulse and later reads a done flag, or a fail flag with a cause code.

The sequence runs as follows. The block first sends wake-up filler bytes with the card deselected. It then sends the reset command frame and polls for the idle reply. After that it repeats an activation attempt until the card reports ready. Each activation attempt consists of a deselect, a filler byte, a reselect and the activation command frame. Every reply wait is bounded by a poll count. The number of activation attempts is also bounded, so the sequence always ends.

Top module: `sd_spi_boot_seq`

## Requirements
- R1: After reset, `card_cs_n` is 1 and `xfer_req`, `done`, `fail` and `fail_cause` are all 0.
- R2: A `start` pulse from the idle, done or fail state begins with WAKE_BYTES transfers of 0xFF, all with `card_cs_n` high.
- R3: Next comes the reset frame with `card_cs_n` low. It is six bytes: 0x40, 0x00, 0x00, 0x00, 0x00, 0x95. Byte 0 is the command index ORed with 0x40, bytes 1 to 4 are the argument with the most significant byte first, and byte 5 is the check byte.
- R4: After the reset frame, the block sends 0xFF poll bytes with `card_cs_n` low until a received byte equals 0x01. Bytes received during frames and filler bytes are ignored.
- R5: A reply wait that sees POLL_LIMIT polls without a match has failed. If this happens in the reset wait, `fail` rises with `fail_cause` = 2'b01 (no idle reply), and `card_cs_n` is high and `xfer_req` is 0 while `fail` is asserted.
- R6: Each activation attempt is one 0xFF with `card_cs_n` high, then the frame 0x41, 0x00, 0x00, 0x00, 0x00, 0xFF with `card_cs_n` low, then 0xFF polls with `card_cs_n` low until a received byte equals 0x00.
- R7: A failed activation wait starts a new attempt. When attempt number MAX_TRIES fails, `fail` rises with `fail_cause` = 2'b10.
- R8: When the ready reply arrives, the block sends one 0xFF with `card_cs_n` high. `done` rises in the cycle after that transfer completes.
- R9: `done` and `fail` stay asserted until the next `start`. That start clears them and restarts the sequence from R2.
- R10: A `start` pulse while a sequence is running has no effect on the byte stream or on the outcome.
- R11: While `xfer_req` is high and `xfer_ack` is low, `xfer_req`, `xfer_tx` and `card_cs_n` hold their values.
- R12: `done` and `fail` are never high together, and `fail_cause` is 0 whenever `fail` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a bring-up sequence |
| xfer_req | output | 1 | A byte transfer is requested |
| xfer_tx | output | 8 | Byte to shift out to the card |
| xfer_ack | input | 1 | Byte-exchange port completes the transfer this cycle |
| xfer_rx | input | 8 | Byte received from the card, valid with `xfer_ack` |
| card_cs_n | output | 1 | Card chip select, active low |
| done | output | 1 | Card is initialized; held until the next start |
| fail | output | 1 | Sequence failed; held until the next start |
| fail_cause | output | 2 | 2'b01 no idle reply, 2'b10 activation attempts exhausted |

## Verification
The hardest cases to reach are at the edges of the two bounds. One is a reply that matches on exactly the last allowed poll. The other is an activation that succeeds only on the final permitted attempt, after the earlier attempts have each run out their full poll budget. The bench reaches both by overriding POLL_LIMIT and MAX_TRIES with small values. Its responder is scripted per scenario, choosing for each wait how many mismatching replies precede the match. It fills command-frame replies with the very values the waits look for, to show that only poll bytes are judged. Acknowledge latency rotates between zero and two idle cycles, so the hold rule is exercised on every stretch of back-pressure.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WAKE,
      ST_RST_CMD,
      ST_RST_POLL,
      ST_GAP,
      ST_ACT_CMD,
      ST_ACT_POLL,
      ST_TAIL,
      ST_DONE,
      ST_FAIL
   } seq_state_t;

   typedef enum logic [1:0] {
      CAUSE_NONE    = 2'b00,
      CAUSE_NO_IDLE = 2'b01,
      CAUSE_TRIES   = 2'b10
   } fail_cause_t;

   localparam int unsigned ARG_BYTES = 4;
   localparam int unsigned FRAME_LEN = ARG_BYTES + 2;
   localparam int unsigned SEL_W     = $clog2(FRAME_LEN);

   localparam logic [7:0] FILL_BYTE   = 8'hFF;
   localparam logic [5:0] RST_IDX     = 6'd0;
   localparam logic [7:0] RST_CHECK   = 8'h95;
   localparam logic [5:0] ACT_IDX     = 6'd1;
   localparam logic [7:0] ACT_CHECK   = 8'hFF;
   localparam logic [7:0] REPLY_IDLE  = 8'h01;
   localparam logic [7:0] REPLY_READY = 8'h00;

endpackage

// File: rtl/sdb_bounded_ctr.sv
module sdb_bounded_ctr #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic at_last
);
   localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("sdb_bounded_ctr: LIMIT must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   assign at_last = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (step)    cnt_q <= at_last ? '0 : cnt_q + 1'b1;
   end

endmodule

// File: rtl/sdb_cmd_frame.sv
module sdb_cmd_frame
   import sdb_pkg::*;
(
   input  logic [5:0]             cmd_idx,
   input  logic [8*ARG_BYTES-1:0] arg,
   input  logic [7:0]             check,
   input  logic [SEL_W-1:0]       sel,
   output logic [7:0]             frame_byte
);
   logic [7:0] bytes [FRAME_LEN];

   assign bytes[0] = {2'b01, cmd_idx};

   generate
      for (genvar gi = 0; gi < ARG_BYTES; gi++) begin : g_arg
         assign bytes[gi+1] = arg[8*(ARG_BYTES-1-gi) +: 8];
      end
   endgenerate

   assign bytes[FRAME_LEN-1] = check;

   always_comb begin
      frame_byte = FILL_BYTE;
      for (int i = 0; i < FRAME_LEN; i++)
         if (sel == SEL_W'(i)) frame_byte = bytes[i];
   end

endmodule

// File: rtl/sd_spi_boot_seq.sv
module sd_spi_boot_seq
   import sdb_pkg::*;
#(
   parameter int unsigned WAKE_BYTES = 10,
   parameter int unsigned POLL_LIMIT = 4095,
   parameter int unsigned MAX_TRIES  = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   output logic       xfer_req,
   output logic [7:0] xfer_tx,
   input  logic       xfer_ack,
   input  logic [7:0] xfer_rx,
   output logic       card_cs_n,
   output logic       done,
   output logic       fail,
   output logic [1:0] fail_cause
);
   localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(FRAME_LEN - 1);

   generate
      if (WAKE_BYTES < 1 || POLL_LIMIT < 1 || MAX_TRIES < 1) begin : g_bad_cfg
         $error("sd_spi_boot_seq: counts must be at least 1");
      end
   endgenerate

   seq_state_t        st_q, st_d;
   fail_cause_t       cause_q, cause_d;
   logic [SEL_W-1:0]  sel_q, sel_d;
   logic              xfer_fire;
   logic              all_clr, poll_clr, wake_step, poll_step, try_step;
   logic              wake_last, poll_last, try_last;
   logic              in_frame, act_frame;
   logic [7:0]        frame_byte;

   assign xfer_fire = xfer_req & xfer_ack;

   sdb_bounded_ctr #(.LIMIT(WAKE_BYTES)) u_wake_ctr (
      .clk(clk), .rst_n(rst_n), .clr(all_clr), .step(wake_step), .at_last(wake_last));

   sdb_bounded_ctr #(.LIMIT(POLL_LIMIT)) u_poll_ctr (
      .clk(clk), .rst_n(rst_n), .clr(all_clr | poll_clr), .step(poll_step), .at_last(poll_last));

   sdb_bounded_ctr #(.LIMIT(MAX_TRIES)) u_try_ctr (
      .clk(clk), .rst_n(rst_n), .clr(all_clr), .step(try_step), .at_last(try_last));

   assign act_frame = (st_q == ST_ACT_CMD);
   assign in_frame  = (st_q == ST_RST_CMD) || act_frame;

   sdb_cmd_frame u_frame (
      .cmd_idx   (act_frame ? ACT_IDX : RST_IDX),
      .arg       ('0),
      .check     (act_frame ? ACT_CHECK : RST_CHECK),
      .sel       (sel_q),
      .frame_byte(frame_byte)
   );

   always_comb begin
      st_d      = st_q;
      cause_d   = cause_q;
      sel_d     = sel_q;
      all_clr   = 1'b0;
      poll_clr  = 1'b0;
      wake_step = 1'b0;
      poll_step = 1'b0;
      try_step  = 1'b0;
      case (st_q)
         ST_IDLE, ST_DONE, ST_FAIL: begin
            if (start) begin
               st_d    = ST_WAKE;
               cause_d = CAUSE_NONE;
               sel_d   = '0;
               all_clr = 1'b1;
            end
         end
         ST_WAKE: begin
            if (xfer_fire) begin
               if (wake_last) st_d = ST_RST_CMD;
               else           wake_step = 1'b1;
            end
         end
         ST_RST_CMD, ST_ACT_CMD: begin
            if (xfer_fire) begin
               if (sel_q == LAST_SEL) begin
                  sel_d    = '0;
                  poll_clr = 1'b1;
                  st_d     = act_frame ? ST_ACT_POLL : ST_RST_POLL;
               end else begin
                  sel_d = sel_q + 1'b1;
               end
            end
         end
         ST_RST_POLL: begin
            if (xfer_fire) begin
               if (xfer_rx == REPLY_IDLE) begin
                  st_d = ST_GAP;
               end else if (poll_last) begin
                  st_d    = ST_FAIL;
                  cause_d = CAUSE_NO_IDLE;
               end else begin
                  poll_step = 1'b1;
               end
            end
         end
         ST_GAP: begin
            if (xfer_fire) st_d = ST_ACT_CMD;
         end
         ST_ACT_POLL: begin
            if (xfer_fire) begin
               if (xfer_rx == REPLY_READY) begin
                  st_d = ST_TAIL;
               end else if (poll_last) begin
                  if (try_last) begin
                     st_d    = ST_FAIL;
                     cause_d = CAUSE_TRIES;
                  end else begin
                     try_step = 1'b1;
                     st_d     = ST_GAP;
                  end
               end else begin
                  poll_step = 1'b1;
               end
            end
         end
         ST_TAIL: begin
            if (xfer_fire) st_d = ST_DONE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cause_q <= CAUSE_NONE;
         sel_q   <= '0;
      end else begin
         st_q    <= st_d;
         cause_q <= cause_d;
         sel_q   <= sel_d;
      end
   end

   always_comb begin
      case (st_q)
         ST_WAKE, ST_RST_CMD, ST_RST_POLL, ST_GAP,
         ST_ACT_CMD, ST_ACT_POLL, ST_TAIL: xfer_req = 1'b1;
         default:                          xfer_req = 1'b0;
      endcase
      case (st_q)
         ST_RST_CMD, ST_RST_POLL, ST_ACT_CMD, ST_ACT_POLL: card_cs_n = 1'b0;
         default:                                          card_cs_n = 1'b1;
      endcase
   end

   assign xfer_tx    = in_frame ? frame_byte : FILL_BYTE;
   assign done       = (st_q == ST_DONE);
   assign fail       = (st_q == ST_FAIL);
   assign fail_cause = cause_q;

   // R11: a pending transfer keeps its byte and select level
   a_r11_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_tx) && $stable(card_cs_n));

   // R12: outcomes exclusive, cause only with fail
   a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));
   a_r12_cause_clean: assert property (@(posedge clk) disable iff (!rst_n)
      !fail |-> fail_cause == CAUSE_NONE);

   // R5: failure leaves the card deselected and the port quiet
   a_r5_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> card_cs_n && !xfer_req);

   // R8: done follows a completed transfer sent with the card deselected
   a_r8_done_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> card_cs_n && $past(xfer_req && xfer_ack && card_cs_n));

   // R9: outcome held until a new start
   a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);
   a_r9_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
      fail && !start |=> fail && $stable(fail_cause));

   // R10: start while busy does not stop the pending transfer
   a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && !xfer_ack && start |=> xfer_req);

endmodule

// File: tb/sd_spi_boot_seq_test.sv
module sd_spi_boot_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int WB = 10;
   localparam int PL = 5;
   localparam int MT = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       xfer_ack = 1'b0;
   logic [7:0] xfer_rx = 8'hA5;
   logic       xfer_req, card_cs_n, done, fail;
   logic [7:0] xfer_tx;
   logic [1:0] fail_cause;

   sd_spi_boot_seq #(.WAKE_BYTES(WB), .POLL_LIMIT(PL), .MAX_TRIES(MT)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
      .card_cs_n(card_cs_n), .done(done), .fail(fail), .fail_cause(fail_cause));

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      logic [7:0] tx;
      logic       cs;
      logic [7:0] rx;
      string      tag;
   } xfer_t;

   xfer_t      q[$];
   int         tq[$];
   int         checks = 0;
   int         fails = 0;
   int         lat = 0;
   int         nxf = 0;
   int         cyc = 0;
   bit         m_done = 0, m_fail = 0, e_done = 0, e_fail = 0;
   logic [1:0] m_cause = 2'b00, e_cause = 2'b00;
   bit         prev_pend = 0;
   logic [7:0] prev_tx = 8'h00;
   logic       prev_cs = 1'b1;

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
      end
   endtask

   function automatic void push(input logic [7:0] tx, input logic cs, input logic [7:0] rx, input string tag);
      xfer_t e;
      e.tx = tx; e.cs = cs; e.rx = rx; e.tag = tag;
      q.push_back(e);
   endfunction

   function automatic void push_frame(input logic [7:0] first, input logic [7:0] last, input logic [7:0] rx, input string tag);
      push(first, 1'b0, rx, tag);
      for (int i = 0; i < 4; i++) push(8'h00, 1'b0, rx, tag);
      push(last, 1'b0, rx, tag);
   endfunction

   // expected byte stream from the requirements; tq holds mismatches per attempt
   function automatic void build(input int idle_k);
      int kt;
      e_done = 0; e_fail = 0; e_cause = 2'b00;
      for (int i = 0; i < WB; i++) push(8'hFF, 1'b1, 8'h01, "R2");
      push_frame(8'h40, 8'h95, 8'h01, "R3");
      for (int j = 0; j < idle_k && j < PL; j++) push(8'hFF, 1'b0, 8'h3F, "R4");
      if (idle_k >= PL) begin
         e_fail = 1; e_cause = 2'b01;   // R5
         return;
      end
      push(8'hFF, 1'b0, 8'h01, "R4");
      for (int t = 0; t < MT; t++) begin
         kt = (t < tq.size()) ? tq[t] : PL;
         push(8'hFF, 1'b1, 8'h00, "R6");
         push_frame(8'h41, 8'hFF, 8'h00, "R6");
         for (int j = 0; j < kt && j < PL; j++) push(8'hFF, 1'b0, 8'h01, "R7");
         if (kt < PL) begin
            push(8'hFF, 1'b0, 8'h00, "R6");
            push(8'hFF, 1'b1, 8'hFF, "R8");
            e_done = 1;
            return;
         end
      end
      e_fail = 1; e_cause = 2'b10;       // R7
   endfunction

   // per-clock reference comparison and responder
   always @(negedge clk) begin
      if (rst_n) begin
         chk(done === m_done, "R9", "done", done, m_done);
         chk(fail === m_fail, "R5", "fail", fail, m_fail);
         chk(fail_cause === m_cause, "R7", "fail_cause", fail_cause, m_cause);
         chk(!(done && fail), "R12", "done&fail", done & fail, 0);
         chk(xfer_req === (q.size() != 0), "R10", "xfer_req", xfer_req, q.size() != 0);
         if (prev_pend) begin
            chk(xfer_req && xfer_tx === prev_tx && card_cs_n === prev_cs,
                "R11", "held tx", xfer_tx, prev_tx);
         end
         prev_pend = 0;
         if (xfer_req && q.size() != 0) begin
            if (lat == 0) begin
               xfer_ack = 1'b1;
               xfer_rx  = q[0].rx;
               chk(xfer_tx === q[0].tx, q[0].tag, "xfer_tx", xfer_tx, q[0].tx);
               chk(card_cs_n === q[0].cs, q[0].tag, "card_cs_n", card_cs_n, q[0].cs);
               void'(q.pop_front());
               nxf++;
               lat = nxf % 3;
               if (q.size() == 0) begin
                  m_done = e_done; m_fail = e_fail; m_cause = e_cause;
               end
            end else begin
               xfer_ack = 1'b0;
               xfer_rx  = 8'hA5;
               lat--;
               prev_pend = 1;
               prev_tx   = xfer_tx;
               prev_cs   = card_cs_n;
            end
         end else begin
            xfer_ack = 1'b0;
            xfer_rx  = 8'hA5;
         end
      end
   end

   task automatic run(input int idle_k, input bit busy_poke);
      @(negedge clk); #1;
      build(idle_k);
      m_done = 0; m_fail = 0; m_cause = 2'b00;
      start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
      if (busy_poke) begin
         // R10: start while busy must leave the stream unchanged
         repeat (20) @(negedge clk);
         #1 start = 1'b1;
         @(negedge clk); #1 start = 1'b0;
      end
      while (q.size() != 0) @(negedge clk);
      repeat (5) @(negedge clk);
      #1;
      chk(done === e_done, e_done ? "R8" : "R9", "final done", done, e_done);
      chk(fail === e_fail, "R5", "final fail", fail, e_fail);
      chk(fail_cause === e_cause, "R7", "final cause", fail_cause, e_cause);
      chk(card_cs_n === 1'b1, "R8", "final cs_n", card_cs_n, 1);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(card_cs_n === 1'b1, "R1", "cs_n in reset", card_cs_n, 1);
      chk(xfer_req === 1'b0, "R1", "req in reset", xfer_req, 0);
      chk(done === 1'b0 && fail === 1'b0, "R1", "flags in reset", {done, fail}, 0);
      chk(fail_cause === 2'b00, "R1", "cause in reset", fail_cause, 0);
      #1 rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(xfer_req === 1'b0 && card_cs_n === 1'b1, "R1", "idle after reset", xfer_req, 0);

      // idle after two misses, first attempt times out, second succeeds
      tq.delete(); tq.push_back(PL); tq.push_back(1);
      run(2, 1'b1);
      // immediate replies; start from done state (R9)
      tq.delete(); tq.push_back(0);
      run(0, 1'b0);
      // matches on the last allowed poll in both waits (R4, R6)
      tq.delete(); tq.push_back(PL-1);
      run(PL-1, 1'b0);
      // no idle reply (R5)
      tq.delete();
      run(PL, 1'b0);
      // every attempt times out (R7)
      tq.delete(); tq.push_back(PL); tq.push_back(PL); tq.push_back(PL);
      run(1, 1'b0);
      // success on the final permitted attempt, started from fail state (R9)
      tq.delete(); tq.push_back(PL); tq.push_back(PL); tq.push_back(2);
      run(3, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule